// File: doc/BRIEF.md
# Two-Level Masked Interrupt Combiner with Power-Up Hold-Off

This block gathers interrupt requests for a USB on-the-go glue device into a single request line. It keeps three register groups: a top-level group, an endpoint group fed by the USB core and a DMA group. Each group has a pending word, a mask word and write ports to set and clear pending bits. Software reaches all of them through a word-wide register port. The two lower groups do not drive the line directly. Each is reduced into summary bits of the top-level pending word. The endpoint group is split by halves, so transmit endpoints and receive endpoints have separate summary bits.

The USB core presents level lines. When a line changes, the top-level pending bit of the same index follows the new level. When the transmit or receive line changes, the endpoint pending word is also reloaded from a word supplied by the core. The request output has a programmable sense. After each rising edge of the power input it is held inactive for a configured number of clock cycles.

Top module: `hirq_combiner`

## Requirements
- R1: A write to a group's set port (port code 1) ORs the written word into that group's pending word, and the result is visible on the next read.
- R2: A write to a group's clear port (port code 2) removes every pending bit that is 1 in the written word and leaves the other bits unchanged.
- R3: A write to a group's mask port (port code 3) replaces the mask word. A read at the pending, set or clear address of a group returns the pending word. A read at the mask address returns the mask. A write to the pending address (port code 0) changes nothing.
- R4: After reset the top-level mask is all ones, every other register is zero and the request output is low.
- R5: After any change to the endpoint group, top-level bit 9 equals 1 exactly when an unmasked endpoint bit in [15:0] is pending. Top-level bit 8 equals 1 exactly when an unmasked endpoint bit in [31:16] is pending.
- R6: After any change to the DMA group, top-level bit 24 equals 1 exactly when any unmasked DMA bit is pending.
- R7: Control register bit 17 sets the sense. When it is 1, the output is high while any unmasked top-level bit is pending. When it is 0, the output is high while none is pending.
- R8: A top-level bit whose mask bit is 1 has no effect on the output.
- R9: A rising edge on the power input forces the output enable low. The enable returns high exactly HOLD_CYC clock cycles after the edge that first sampled power high, but only if power is still high at that point. Otherwise the enable stays low until the next rising edge.
- R10: When core line N changes level, top-level pending bit N takes the new level on the next clock edge.
- R11: When core line 9 (transmit) or core line 8 (receive) changes, the endpoint pending word is reloaded from the core word. The level of the changed line then overrides its own summary bit.
- R12: Address bits [3:2] select the group: 0 top-level, 1 endpoint, 2 DMA, 3 control. Bits [1:0] select the port. The control register is at address 12. Addresses 13 to 15 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address: group in [3:2], port in [1:0] |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| core_lvl | input | CORE_N | Level lines from the USB core |
| core_word | input | 32 | Endpoint pending word supplied by the core |
| pwr_on | input | 1 | Power-good input |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A wrong summary bit or a wrong pending bit shows up in the top-level pending word at the next read, one clock after the write or line change that caused it. Through the sense and mask logic it also reaches irq_o in that same cycle. A fault in the hold-off counter shows as the request rising one or more cycles too early or too late, or never rising. For that reason the bench samples the cycle before and the cycle of the expected release. Sweeps over every bit position of each group catch faults in single bits or in the half split of the endpoint group.

// File: rtl/hirq_pkg.sv
package hirq_pkg;

    localparam int unsigned DW   = 32;
    localparam int unsigned AW   = 4;
    localparam int unsigned HALF = DW / 2;
    localparam int unsigned NGRP = 3;

    typedef logic [DW-1:0] word_t;

    // port field reg_addr[1:0]
    typedef enum logic [1:0] {
        PT_SRC  = 2'd0,
        PT_SET  = 2'd1,
        PT_CLR  = 2'd2,
        PT_MASK = 2'd3
    } port_e;

    // group field reg_addr[3:2]
    typedef enum logic [1:0] {
        GR_MAIN = 2'd0,
        GR_EP   = 2'd1,
        GR_DMA  = 2'd2,
        GR_CTRL = 2'd3
    } grp_e;

    localparam int unsigned BIT_EP_RX = 8;
    localparam int unsigned BIT_EP_TX = 9;
    localparam int unsigned BIT_DMA   = 24;
    localparam int unsigned BIT_SENSE = 17;

    localparam word_t MAIN_MASK_RST = {DW{1'b1}};

    typedef struct packed {
        logic set;
        logic clr;
        logic msk;
    } gwr_t;

    function automatic logic any_live(input word_t src, input word_t mask);
        return |(src & ~mask);
    endfunction

endpackage

// File: rtl/hirq_group.sv
module hirq_group
    import hirq_pkg::*;
#(
    parameter word_t MASK_RST = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  gwr_t  wr,
    input  word_t wdata,
    input  word_t ovr_en,
    input  word_t ovr_val,
    output word_t src_q,
    output word_t mask_q,
    output word_t src_d,
    output word_t mask_d
);

    word_t after_wr;

    always_comb begin
        after_wr = src_q;
        if (wr.set) after_wr = src_q | wdata;
        if (wr.clr) after_wr = src_q & ~wdata;
        src_d  = (after_wr & ~ovr_en) | (ovr_val & ovr_en);
        mask_d = wr.msk ? wdata : mask_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            mask_q <= MASK_RST;
        end else begin
            src_q  <= src_d;
            mask_q <= mask_d;
        end
    end

    AST_SET_ORS: assert property (@(posedge clk) disable iff (rst) (wr.set && ovr_en == '0) |=> ((src_q & $past(wdata)) == $past(wdata))) else $error("set port lost bits"); // R1
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst) (wr.clr && ovr_en == '0) |=> ((src_q & $past(wdata)) == '0)) else $error("clear port left bits"); // R2
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst) wr.msk |=> (mask_q == $past(wdata))) else $error("mask not replaced"); // R3
    AST_SRC_QUIET: assert property (@(posedge clk) disable iff (rst) (!wr.set && !wr.clr && ovr_en == '0) |=> $stable(src_q)) else $error("pending word moved without cause"); // R3

endmodule

// File: rtl/hirq_lines.sv
module hirq_lines #(
    parameter int unsigned N = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] chg
);

    logic [N-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= lvl;
    end

    assign chg = lvl ^ lvl_q;

endmodule

// File: rtl/hirq_holdoff.sv
module hirq_holdoff #(
    parameter int unsigned HOLD_CYC = 30_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr,
    output logic en
);

    localparam int unsigned CW = $clog2(HOLD_CYC + 1);

    logic          pwr_q;
    logic          armed;
    logic [CW-1:0] cnt;
    logic          rise;

    assign rise = pwr & ~pwr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_q <= 1'b0;
            armed <= 1'b0;
            cnt   <= '0;
            en    <= 1'b0;
        end else begin
            pwr_q <= pwr;
            if (rise) begin
                armed <= 1'b1;
                cnt   <= CW'(HOLD_CYC - 1);
                en    <= 1'b0;
            end else if (armed) begin
                if (cnt == '0) begin
                    armed <= 1'b0;
                    en    <= pwr;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    AST_RISE_BLOCKS: assert property (@(posedge clk) disable iff (rst) rise |=> !en) else $error("enable not dropped on power edge"); // R9
    AST_EN_NEEDS_PWR: assert property (@(posedge clk) disable iff (rst) $rose(en) |-> $past(pwr)) else $error("enable rose without power"); // R9

endmodule

// File: rtl/hirq_combiner.sv
module hirq_combiner
    import hirq_pkg::*;
#(
    parameter int unsigned CORE_N   = 10,
    parameter int unsigned HOLD_CYC = 30_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [CORE_N-1:0] core_lvl,
    input  logic [31:0]       core_word,
    input  logic              pwr_on,
    output logic              irq_o
);

    grp_e  a_grp;
    port_e a_port;
    assign a_grp  = grp_e'(reg_addr[3:2]);
    assign a_port = port_e'(reg_addr[1:0]);

    gwr_t  gw       [NGRP];
    word_t g_src    [NGRP];
    word_t g_mask   [NGRP];
    word_t g_src_d  [NGRP];
    word_t g_mask_d [NGRP];
    word_t g_ovr_en [NGRP];
    word_t g_ovr_val[NGRP];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic hit;
        assign hit   = reg_wr && (a_grp == grp_e'(g));
        assign gw[g] = '{set: hit && (a_port == PT_SET),
                         clr: hit && (a_port == PT_CLR),
                         msk: hit && (a_port == PT_MASK)};
        hirq_group #(
            .MASK_RST((g == 0) ? MAIN_MASK_RST : word_t'(0))
        ) u_grp (
            .clk    (clk),
            .rst    (rst),
            .wr     (gw[g]),
            .wdata  (reg_wdata),
            .ovr_en (g_ovr_en[g]),
            .ovr_val(g_ovr_val[g]),
            .src_q  (g_src[g]),
            .mask_q (g_mask[g]),
            .src_d  (g_src_d[g]),
            .mask_d (g_mask_d[g])
        );
    end

    logic [CORE_N-1:0] line_chg;

    hirq_lines #(.N(CORE_N)) u_lines (
        .clk(clk),
        .rst(rst),
        .lvl(core_lvl),
        .chg(line_chg)
    );

    logic hold_en;

    hirq_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk(clk),
        .rst(rst),
        .pwr(pwr_on),
        .en (hold_en)
    );

    word_t ctrl_q;
    always_ff @(posedge clk) begin
        if (rst)                                              ctrl_q <= '0;
        else if (reg_wr && a_grp == GR_CTRL && a_port == PT_SRC) ctrl_q <= reg_wdata;
    end

    logic ep_load, ep_touch, dma_touch;
    assign ep_load   = line_chg[BIT_EP_TX] | line_chg[BIT_EP_RX];
    assign ep_touch  = (|gw[GR_EP]) | ep_load;
    assign dma_touch = |gw[GR_DMA];

    always_comb begin
        g_ovr_en[GR_MAIN]  = '0;
        g_ovr_val[GR_MAIN] = '0;
        if (ep_touch) begin
            g_ovr_en[GR_MAIN][BIT_EP_TX]  = 1'b1;
            g_ovr_en[GR_MAIN][BIT_EP_RX]  = 1'b1;
            g_ovr_val[GR_MAIN][BIT_EP_TX] = |(g_src_d[GR_EP][HALF-1:0] & ~g_mask_d[GR_EP][HALF-1:0]);
            g_ovr_val[GR_MAIN][BIT_EP_RX] = |(g_src_d[GR_EP][DW-1:HALF] & ~g_mask_d[GR_EP][DW-1:HALF]);
        end
        if (dma_touch) begin
            g_ovr_en[GR_MAIN][BIT_DMA]  = 1'b1;
            g_ovr_val[GR_MAIN][BIT_DMA] = any_live(g_src_d[GR_DMA], g_mask_d[GR_DMA]);
        end
        for (int n = 0; n < CORE_N; n++) begin
            if (line_chg[n]) begin
                g_ovr_en[GR_MAIN][n]  = 1'b1;
                g_ovr_val[GR_MAIN][n] = core_lvl[n];
            end
        end
        g_ovr_en[GR_EP]   = ep_load ? {DW{1'b1}} : '0;
        g_ovr_val[GR_EP]  = core_word;
        g_ovr_en[GR_DMA]  = '0;
        g_ovr_val[GR_DMA] = '0;
    end

    always_comb begin
        reg_rdata = '0;
        case (a_grp)
            GR_CTRL: reg_rdata = (a_port == PT_SRC) ? ctrl_q : '0;
            default: reg_rdata = (a_port == PT_MASK) ? g_mask[a_grp] : g_src[a_grp];
        endcase
    end

    logic live;
    assign live  = any_live(g_src[GR_MAIN], g_mask[GR_MAIN]);
    assign irq_o = hold_en & (ctrl_q[BIT_SENSE] ? live : ~live);

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst) !hold_en |-> !irq_o) else $error("request while held off"); // R9
    AST_EP_SUMMARY: assert property (@(posedge clk) disable iff (rst) (ep_touch && !ep_load) |=> (g_src[GR_MAIN][BIT_EP_TX] == |(g_src[GR_EP][HALF-1:0] & ~g_mask[GR_EP][HALF-1:0]) && g_src[GR_MAIN][BIT_EP_RX] == |(g_src[GR_EP][DW-1:HALF] & ~g_mask[GR_EP][DW-1:HALF]))) else $error("endpoint summary stale"); // R5
    AST_DMA_SUMMARY: assert property (@(posedge clk) disable iff (rst) dma_touch |=> (g_src[GR_MAIN][BIT_DMA] == |(g_src[GR_DMA] & ~g_mask[GR_DMA]))) else $error("dma summary stale"); // R6

    for (genvar n = 0; n < CORE_N; n++) begin : g_line_chk
        AST_LINE_FOLLOW: assert property (@(posedge clk) disable iff (rst) line_chg[n] |=> (g_src[GR_MAIN][n] == $past(core_lvl[n]))) else $error("line bit did not follow"); // R10
    end

endmodule

// File: tb/hirq_combiner_bench.sv
module hirq_combiner_bench;

    localparam int unsigned CN   = 10;
    localparam int unsigned HOLD = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [CN-1:0] core_lvl = '0;
    logic [31:0]   core_word = '0;
    logic          pwr_on = 1'b0;
    logic          irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    hirq_combiner #(.CORE_N(CN), .HOLD_CYC(HOLD)) u_hirq_combiner (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_lvl(core_lvl),
        .core_word(core_word), .pwr_on(pwr_on), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rdchk(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic irqchk(input string req, input logic exp);
        @(negedge clk);
        #1 chk(req, {31'b0, irq_o}, {31'b0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] e;
        logic [31:0] p;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R4 reset values
        for (int a = 0; a < 16; a++)
            rdchk("R4", 4'(a), (a == 3) ? 32'hFFFF_FFFF : 32'h0);
        irqchk("R4", 1'b0);

        // R9 hold-off timing
        @(negedge clk) pwr_on = 1'b1;
        @(posedge clk);
        repeat (HOLD - 1) @(posedge clk);
        #1 chk("R9 early", {31'b0, irq_o}, 32'h0);
        @(posedge clk);
        #1 chk("R9 release", {31'b0, irq_o}, 32'h1);
        // R9 power lost inside window
        @(negedge clk) pwr_on = 1'b0;
        @(negedge clk) pwr_on = 1'b1;
        @(negedge clk) pwr_on = 1'b0;
        repeat (HOLD + 4) @(negedge clk);
        #1 chk("R9 aborted", {31'b0, irq_o}, 32'h0);
        @(negedge clk) pwr_on = 1'b1;
        repeat (HOLD + 3) @(negedge clk);
        #1 chk("R9 rearm", {31'b0, irq_o}, 32'h1);

        // R1 R2 R7 set/clear sweeps with positive sense
        wr(4'd12, 32'h1 << 17);
        rdchk("R12 ctrl", 4'd12, 32'h1 << 17);
        irqchk("R7 idle", 1'b0);
        wr(4'd3, 32'h0);
        e = 32'h0;
        for (int k = 0; k < 32; k++) begin
            wr(4'd1, 32'h1 << k);
            e |= 32'h1 << k;
            rdchk("R1", 4'd0, e);
        end
        irqchk("R7 live", 1'b1);
        wr(4'd12, 32'h0);
        irqchk("R7 inverted", 1'b0);
        wr(4'd12, 32'h1 << 17);
        for (int k = 0; k < 32; k++) begin
            wr(4'd2, 32'h1 << k);
            e &= ~(32'h1 << k);
            rdchk("R2", 4'd0, e);
        end
        irqchk("R7 drained", 1'b0);

        // R8 mask sweep
        p = 32'h5A3C_96E1;
        wr(4'd1, p);
        rdchk("R3 set addr", 4'd1, p);
        rdchk("R3 clr addr", 4'd2, p);
        for (int k = 0; k < 32; k++) begin
            wr(4'd3, ~(32'h1 << k));
            rdchk("R3 mask", 4'd3, ~(32'h1 << k));
            irqchk("R8", p[k]);
        end
        wr(4'd3, 32'hFFFF_FFFF);
        irqchk("R8 all masked", 1'b0);
        // R3 R12 write to pending address ignored, unmapped zero
        wr(4'd0, 32'h0000_FFFF);
        rdchk("R3 src write", 4'd0, p);
        wr(4'd2, 32'hFFFF_FFFF);
        for (int a = 13; a < 16; a++) rdchk("R12 unmapped", 4'(a), 32'h0);

        // R5 endpoint summary sweep
        for (int b = 0; b < 32; b++) begin
            wr(4'd5, 32'h1 << b);
            rdchk("R5 ep src", 4'd4, 32'h1 << b);
            rdchk("R5", 4'd0, (b < 16) ? (32'h1 << 9) : (32'h1 << 8));
            wr(4'd6, 32'h1 << b);
            rdchk("R5 cleared", 4'd0, 32'h0);
        end
        wr(4'd7, 32'h0000_FFFF);
        wr(4'd5, 32'h0001_0001);
        rdchk("R5 masked half", 4'd0, 32'h1 << 8);
        wr(4'd7, 32'h0);
        rdchk("R5 unmask", 4'd0, 32'h3 << 8);
        wr(4'd6, 32'hFFFF_FFFF);

        // R6 DMA summary sweep
        for (int b = 0; b < 32; b++) begin
            wr(4'd9, 32'h1 << b);
            rdchk("R6", 4'd0, 32'h1 << 24);
            wr(4'd10, 32'h1 << b);
            rdchk("R6 cleared", 4'd0, 32'h0);
        end
        wr(4'd9, 32'h0000_0100);
        wr(4'd11, 32'h0000_0100);
        rdchk("R6 masked", 4'd0, 32'h0);
        rdchk("R3 dma mask", 4'd11, 32'h0000_0100);
        wr(4'd11, 32'h0);
        rdchk("R6 unmask", 4'd0, 32'h1 << 24);
        wr(4'd10, 32'hFFFF_FFFF);

        // R10 R11 core lines
        core_word = 32'h0003_0040;
        for (int n = 0; n < CN; n++) begin
            wr(4'd6, 32'hFFFF_FFFF);
            wr(4'd2, 32'hFFFF_FFFF);
            for (int lv = 1; lv >= 0; lv--) begin
                @(negedge clk) core_lvl[n] = 1'(lv);
                @(negedge clk);
                e = 32'h0;
                if (n == 8 || n == 9) e = 32'h3 << 8;
                e[n] = 1'(lv);
                rdchk((n >= 8) ? "R11" : "R10", 4'd0, e);
                rdchk("R11 ep reload", 4'd4, (n >= 8) ? core_word : 32'h0);
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule